// File: doc/BRIEF.md
# Steerable Dual-Output Interrupt Controller

This block gathers sixteen active-low external interrupt lines and one active-low high-priority line and merges them onto two processor inputs: a fast-interrupt line and a normal-interrupt line. Every source has its own enable bit and its own steering bit. An enabled source raises exactly one of the two outputs, the one its steering bit selects. Each external pin can also serve as general-purpose I/O. The four lowest pins are taken over as endpoint interrupt outputs when endpoint mode is on. In both cases the pin's interrupt contribution is forced off.

Two separate non-maskable paths, one per core, synchronize their pins and look for a falling edge. Each path is a small state machine with two states. `NMI_IDLE` moves to `NMI_HELD` when a falling edge is detected. `NMI_HELD` stays put until software writes 1 to that core's flag bit. It then returns to `NMI_IDLE`, unless a new falling edge arrives in that same cycle, in which case it remains in `NMI_HELD`. The enable register never touches these paths.

A plain register port (write strobe, address, write data, combinational read data) holds the configuration and reports synchronized pending status. Vector generation and priority among sources are left to the processor side.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset, all sources are disabled and steered to the normal output, all pins are in general-purpose mode, endpoint mode is off, every register reads 0, and `fiq_o`, `irq_o`, `nmi_o` and `ep_drive_low` are all 0.
- R2: An external source i with enable bit i set, pin-mode bit i set and its pin held low raises `fiq_o` when steering bit i is 1, or `irq_o` when it is 0. The output is visible after two rising clock edges. Several sources may raise both outputs at once.
- R3: A source whose enable bit is 0 affects neither output, whatever its pin level.
- R4: An external source whose pin-mode bit is 0 (general-purpose) affects neither output, even when enabled and low.
- R5: With endpoint mode on, sources 0 to 3 affect neither output, and `ep_drive_low[j]` follows `ep_int_req[j]`. With endpoint mode off, `ep_drive_low` is 0. Sources 4 to 15 are unaffected by endpoint mode.
- R6: The high-priority input `hp_irq_n` uses enable bit 16 and steering bit 16 (1 = fast) and needs no pin-mode bit.
- R7: Address 4 reads the synchronized, active-high status of every source, regardless of enable, pin mode and endpoint mode: bits 15:0 for the external pins and bit 16 for the high-priority input.
- R8: A falling edge on `nmi_n[c]` asserts `nmi_o[c]` on the third rising edge after the pin falls. The other core is not affected, and the enable register has no effect.
- R9: `nmi_o[c]` stays asserted until a write to address 5 with bit c = 1. Writing 0 to bit c leaves it set. Address 5 bits 1:0 read the current flags.
- R10: A non-maskable pin that stays low does not assert the output again after a clear. Only a new high-to-low transition does.
- R11: If a clear write for core c falls in the same cycle as a detected falling edge on that core, `nmi_o[c]` stays asserted.
- R12: Register map: address 0 is the enable bits [16:0], address 1 is the steering bits [16:0], address 2 is the pin-mode bits [15:0] (1 = interrupt input), and address 3 bit 0 is endpoint mode. Written values read back, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 16 | External interrupt pins, active low |
| hp_irq_n | input | 1 | High-priority interrupt, active low |
| nmi_n | input | 2 | Non-maskable pins, one per core, falling-edge |
| ep_int_req | input | 4 | Endpoint interrupt requests A to D |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |
| nmi_o | output | 2 | Per-core non-maskable request |
| ep_drive_low | output | 4 | Drive-low enables for endpoint pins 0 to 3 |

## Verification
The delicate coincidence is a software clear of a non-maskable flag landing in the same cycle as a fresh falling edge on that core's pin. The bench first lets the pin return high while the flag is still held. It then pulls the pin low and times the clear write for the second cycle after the pin falls, which is exactly when the edge detector fires. The output must remain asserted. A plain clear is then applied with the pin still low, and the output must drop and stay low.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;

    typedef enum logic [2:0] {
        ADDR_ENABLE  = 3'd0,
        ADDR_STEER   = 3'd1,
        ADDR_PINMODE = 3'd2,
        ADDR_EPMODE  = 3'd3,
        ADDR_PENDING = 3'd4,
        ADDR_NMIFLAG = 3'd5
    } reg_addr_e;

    typedef enum logic {
        NMI_IDLE = 1'b0,
        NMI_HELD = 1'b1
    } nmi_state_e;

endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
    parameter int WIDTH = 1,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RESET_VAL;
                end else begin
                    if (s == 0) stage_q[s] <= d;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NUM_SRC = 16,
    parameter int NUM_EP = 4
) (
    input  logic [NUM_SRC:0]   pending,
    input  logic [NUM_SRC:0]   enable,
    input  logic [NUM_SRC:0]   steer,
    input  logic [NUM_SRC-1:0] pinmode,
    input  logic               epmode,
    output logic               fiq,
    output logic               irq
);
    logic [NUM_SRC:0] live;

    always_comb begin
        live = pending & enable;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (!pinmode[i]) live[i] = 1'b0;
        end
        for (int i = 0; i < NUM_EP; i++) begin
            if (epmode) live[i] = 1'b0;
        end
    end

    assign fiq = |(live & steer);
    assign irq = |(live & ~steer);
endmodule

// File: rtl/irq_nmi_fsm.sv
module irq_nmi_fsm
    import irq_steer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_sync_n,
    input  logic clr,
    output logic held_o
);
    nmi_state_e state_q, state_d;
    logic       prev_q;
    logic       fall;

    assign fall = prev_q & ~pin_sync_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NMI_IDLE;
            prev_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            prev_q  <= pin_sync_n;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE: if (fall) state_d = NMI_HELD;
            NMI_HELD: if (clr && !fall) state_d = NMI_IDLE;
            default:  state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        held_o = (state_q == NMI_HELD);
    end

    AST_NMI_CATCH: assert property (@(posedge clk) disable iff (!rst_n) fall |=> held_o); // R8
    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (held_o && !clr) |=> held_o); // R9
    AST_NMI_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!held_o && !fall) |=> !held_o); // R10
    AST_NMI_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (clr && fall) |=> held_o); // R11
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
    import irq_steer_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_EP = 4,
    parameter int NUM_CORE = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  ext_irq_n,
    input  logic                hp_irq_n,
    input  logic [NUM_CORE-1:0] nmi_n,
    input  logic [NUM_EP-1:0]   ep_int_req,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                fiq_o,
    output logic                irq_o,
    output logic [NUM_CORE-1:0] nmi_o,
    output logic [NUM_EP-1:0]   ep_drive_low
);
    localparam int SRC_ALL = NUM_SRC + 1;

    logic [SRC_ALL-1:0]  enable_q, steer_q;
    logic [NUM_SRC-1:0]  pinmode_q;
    logic                epmode_q;
    logic [SRC_ALL-1:0]  sync_n, pending;
    logic [NUM_CORE-1:0] nmi_sync_n, nmi_clr;
    logic                unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SRC_ALL];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q  <= '0;
            steer_q   <= '0;
            pinmode_q <= '0;
            epmode_q  <= 1'b0;
        end else if (reg_we) begin
            unique case (reg_addr_e'(reg_addr))
                ADDR_ENABLE:  enable_q  <= reg_wdata[SRC_ALL-1:0];
                ADDR_STEER:   steer_q   <= reg_wdata[SRC_ALL-1:0];
                ADDR_PINMODE: pinmode_q <= reg_wdata[NUM_SRC-1:0];
                ADDR_EPMODE:  epmode_q  <= reg_wdata[0];
                default: ;
            endcase
        end
    end

    assign nmi_clr = (reg_we && reg_addr == ADDR_NMIFLAG) ? reg_wdata[NUM_CORE-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr_e'(reg_addr))
            ADDR_ENABLE:  reg_rdata[SRC_ALL-1:0]  = enable_q;
            ADDR_STEER:   reg_rdata[SRC_ALL-1:0]  = steer_q;
            ADDR_PINMODE: reg_rdata[NUM_SRC-1:0]  = pinmode_q;
            ADDR_EPMODE:  reg_rdata[0]            = epmode_q;
            ADDR_PENDING: reg_rdata[SRC_ALL-1:0]  = pending;
            ADDR_NMIFLAG: reg_rdata[NUM_CORE-1:0] = nmi_o;
            default:      reg_rdata = '0;
        endcase
    end

    irq_sync_bank #(.WIDTH(SRC_ALL), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_src_sync (
        .clk(clk), .rst_n(rst_n), .d({hp_irq_n, ext_irq_n}), .q(sync_n)
    );

    assign pending = ~sync_n;

    irq_route #(.NUM_SRC(NUM_SRC), .NUM_EP(NUM_EP)) u_route (
        .pending(pending), .enable(enable_q), .steer(steer_q),
        .pinmode(pinmode_q), .epmode(epmode_q), .fiq(fiq_o), .irq(irq_o)
    );

    assign ep_drive_low = epmode_q ? ep_int_req : '0;

    irq_sync_bank #(.WIDTH(NUM_CORE), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_sync_n)
    );

    genvar c;
    generate
        for (c = 0; c < NUM_CORE; c++) begin : g_core
            irq_nmi_fsm u_nmi (
                .clk(clk), .rst_n(rst_n), .pin_sync_n(nmi_sync_n[c]),
                .clr(nmi_clr[c]), .held_o(nmi_o[c])
            );
        end
    endgenerate

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (enable_q == '0) |-> !(fiq_o || irq_o)); // R3
    AST_GPIO_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (pinmode_q == '0 && !enable_q[NUM_SRC]) |-> !(fiq_o || irq_o)); // R4
    AST_EP_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (epmode_q && enable_q[SRC_ALL-1:NUM_EP] == '0) |-> !(fiq_o || irq_o)); // R5
    AST_EP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !epmode_q |-> (ep_drive_low == '0)); // R5
endmodule

// File: tb/irq_steer_ctrl_tb.sv
module irq_steer_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_irq_n = '1;
    logic        hp_irq_n = 1'b1;
    logic [1:0]  nmi_n = '1;
    logic [3:0]  ep_int_req = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fiq_o, irq_o;
    logic [1:0]  nmi_o;
    logic [3:0]  ep_drive_low;

    int n_checks = 0;
    int n_fail = 0;

    irq_steer_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .hp_irq_n(hp_irq_n),
        .nmi_n(nmi_n), .ep_int_req(ep_int_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fiq_o(fiq_o), .irq_o(irq_o),
        .nmi_o(nmi_o), .ep_drive_low(ep_drive_low)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [16:0] mask;
        logic [16:0] steer;
        logic [15:0] mode;
        logic        ep;
        logic [15:0] pin_n;
        logic        hp_n;
        logic        fiq;
        logic        irq;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{17'h00001, 17'h00000, 16'h0001, 1'b0, 16'hFFFE, 1'b1, 1'b0, 1'b1}, // R2 normal
        '{17'h00001, 17'h00001, 16'h0001, 1'b0, 16'hFFFE, 1'b1, 1'b1, 1'b0}, // R2 fast
        '{17'h00000, 17'h00000, 16'h0001, 1'b0, 16'hFFFE, 1'b1, 1'b0, 1'b0}, // R3
        '{17'h00001, 17'h00000, 16'h0000, 1'b0, 16'hFFFE, 1'b1, 1'b0, 1'b0}, // R4
        '{17'h0000F, 17'h00000, 16'h000F, 1'b1, 16'hF0F0, 1'b1, 1'b0, 1'b0}, // R5
        '{17'h10000, 17'h10000, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b1, 1'b0}, // R6 fast
        '{17'h10000, 17'h00000, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b0, 1'b1}, // R6 normal
        '{17'h08001, 17'h08000, 16'h8001, 1'b0, 16'h7FFE, 1'b1, 1'b1, 1'b1}, // R2 both
        '{17'h00030, 17'h00010, 16'h0030, 1'b1, 16'hFFCF, 1'b1, 1'b1, 1'b1}  // R5 upper
    };

    function automatic string vec_tag(int i);
        case (i)
            2: return "R3";
            3: return "R4";
            4, 8: return "R5";
            5, 6: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        ep_int_req = 4'hF;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check({fiq_o, irq_o, nmi_o, ep_drive_low} == '0, "R1", {fiq_o, irq_o, nmi_o, ep_drive_low}, 0);
        for (int a = 0; a < 6; a++) rd_check(3'(a), 32'h0, "R1");

        // R12 register readback
        wr(3'd0, 32'hFFFF_FFFF); rd_check(3'd0, 32'h0001_FFFF, "R12");
        wr(3'd1, 32'hFFFF_FFFF); rd_check(3'd1, 32'h0001_FFFF, "R12");
        wr(3'd2, 32'hFFFF_FFFF); rd_check(3'd2, 32'h0000_FFFF, "R12");
        wr(3'd3, 32'hFFFF_FFFF); rd_check(3'd3, 32'h0000_0001, "R12");

        // table walk
        for (int v = 0; v < 9; v++) begin
            ext_irq_n = VECS[v].pin_n;
            hp_irq_n  = VECS[v].hp_n;
            wr(3'd0, 32'(VECS[v].mask));
            wr(3'd1, 32'(VECS[v].steer));
            wr(3'd2, 32'(VECS[v].mode));
            wr(3'd3, 32'(VECS[v].ep));
            cycles(3);
            check({fiq_o, irq_o} == {VECS[v].fiq, VECS[v].irq}, vec_tag(v),
                  {30'h0, fiq_o, irq_o}, {30'h0, VECS[v].fiq, VECS[v].irq});
        end

        // R2 latency: two edges after the pin falls
        ext_irq_n = '1; hp_irq_n = 1'b1;
        wr(3'd0, 32'h1); wr(3'd1, 32'h0); wr(3'd2, 32'h1); wr(3'd3, 32'h0);
        cycles(3);
        ext_irq_n = 16'hFFFE;
        cycles(1);
        check(irq_o == 1'b0, "R2", irq_o, 0);
        cycles(1);
        check(irq_o == 1'b1, "R2", irq_o, 1);

        // R5 endpoint drive
        ep_int_req = 4'b1010;
        wr(3'd3, 32'h1);
        check(ep_drive_low == 4'b1010, "R5", ep_drive_low, 4'b1010);
        wr(3'd3, 32'h0);
        check(ep_drive_low == 4'b0000, "R5", ep_drive_low, 0);

        // R7 pending ignores mask and mode
        wr(3'd0, 32'h0); wr(3'd2, 32'h0);
        ext_irq_n = 16'hA5A5; hp_irq_n = 1'b0;
        cycles(3);
        rd_check(3'd4, 32'h0001_5A5A, "R7");
        check({fiq_o, irq_o} == 2'b00, "R3", {fiq_o, irq_o}, 0);
        ext_irq_n = '1; hp_irq_n = 1'b1;

        // R8 nmi edge, mask disabled, latency
        nmi_n[0] = 1'b0;
        cycles(2);
        check(nmi_o == 2'b00, "R8", nmi_o, 0);
        cycles(1);
        check(nmi_o == 2'b01, "R8", nmi_o, 2'b01);
        rd_check(3'd5, 32'h1, "R9");

        // R9 write 0 keeps flag
        wr(3'd5, 32'h0);
        check(nmi_o == 2'b01, "R9", nmi_o, 2'b01);

        // R10 clear with pin low, no retrigger
        wr(3'd5, 32'h1);
        check(nmi_o == 2'b00, "R9", nmi_o, 0);
        cycles(5);
        check(nmi_o == 2'b00, "R10", nmi_o, 0);
        nmi_n[0] = 1'b1;
        cycles(3);
        nmi_n[0] = 1'b0;
        cycles(3);
        check(nmi_o == 2'b01, "R10", nmi_o, 2'b01);

        // R11 clear coincident with new falling edge
        nmi_n[0] = 1'b1;
        cycles(3);
        check(nmi_o == 2'b01, "R9", nmi_o, 2'b01);
        nmi_n[0] = 1'b0;
        cycles(2);
        wr(3'd5, 32'h1);
        check(nmi_o == 2'b01, "R11", nmi_o, 2'b01);
        wr(3'd5, 32'h1);
        check(nmi_o == 2'b00, "R11", nmi_o, 0);

        // R8 second core independent
        nmi_n[1] = 1'b0;
        cycles(3);
        check(nmi_o == 2'b10, "R8", nmi_o, 2'b10);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule